// File: doc/BRIEF.md
# Cascadable 8-bit PWM Timer Pair

This block holds two 8-bit up-counters that share one write-only register port. Each counter takes its count pulses from one of seven taps of a free-running system-clock prescaler (divide by 1, 2, 8, 32, 64, 1024 or 8192) or from the rising edges of its own external clock pin. The pin is synchronized to the system clock first. Compare A sets the period because a match clears the counter. Compare B sets the point where the output falls. Each channel therefore drives one pin with a pulse-width-modulated waveform of any duty cycle.

A mode bit joins the two channels into one 16-bit counter. The lower channel supplies the count pulses, and the upper channel counts the lower channel's overflows. Both compares then act on the joined 16-bit value, so the 16-bit waveform comes out on pin 0. Compare writes go to holding registers. They reach the comparators only when the counter returns to zero, or at once while the channel is stopped, so a running waveform never shows a short or split pulse. Overflow and match events set sticky flags, and software clears them with a write-one-to-clear register.

Top module: `tmr_pair`

## Requirements
- R1: The control register for channel 0 is at address 0 and for channel 1 at address 1. Its bits [3:0] select the count source, where code 1..7 counts every 1, 2, 8, 32, 64, 1024 or 8192 system clocks.
- R2: Source code 0 and codes 9..15 stop the channel. A stopped counter holds its value.
- R3: Source code 8 counts rising edges of that channel's external clock pin, after a two-stage synchronizer. A pin held at a constant level does not count.
- R4: Compare A, at address 2 (channel 0) or address 4 (channel 1), clears the counter to 0 on the count pulse where the counter equals it. The count runs 0..A, giving a period of A+1 count pulses.
- R5: Compare B, at address 3 (channel 0) or address 5 (channel 1), sets the output: it is high while the count is below B and low otherwise. B=0 gives a constant low and B>A gives a constant high.
- R6: Control bit 4 inverts that channel's output pin.
- R7: A compare write takes effect only when the counter next returns to 0, or at once while the channel is stopped.
- R8: Bit 5 of the channel-1 control register joins the channels, with channel 0's source driving the count. The upper counter advances only when the lower counter wraps. Compares use {A1,A0} and {B1,B0}, pin 0 carries the 16-bit waveform, and pin 1 sits at the level of its invert bit.
- R9: The flags are: bit 0/3 overflow of channel 0/1, bit 1/4 compare-A match, bit 2/5 compare-B match. Each is set on a count pulse where the counter is all ones, equals A, or equals B. Flags stay set until a 1 is written to that bit at address 6, and a new event on the same cycle wins over the clear. In joined mode bits 0 and 3 are the low and 16-bit overflow, bits 1 and 2 are the 16-bit matches, and bits 4 and 5 stay clear.
- R10: After reset both counters are 0, all compares are all ones, both sources are stopped, the flags are clear and both pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| extIn | input | 2 | External count clock per channel |
| pwmOut | output | 2 | Waveform pin per channel |
| cnt0 | output | 8 | Channel 0 count value |
| cnt1 | output | 8 | Channel 1 count value |
| flags | output | 6 | Sticky event flags |

## Verification
The bench goes after the compare timing. A design that loads a new compare value immediately would clear early in the middle of a period, and the bench catches this by lowering A while the count sits below the new value. It also tests duty-cycle edges: B=0, B above A and the inverted pin. A comparator written with `<=` instead of `<` would add one high count per period. In joined mode the bench checks that the upper byte moves only on the lower wrap and that pin 1 stays quiet, since a design that also let channel 1's own clock run would show a spurious period on pin 1. The flag tests check that a partial clear leaves the other bits alone and that a compare-A clear without an all-ones count does not raise overflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PRE_W = 13;
  localparam int NUM_CH = 2;
  localparam int FLAG_W = 6;

  localparam logic [2:0] ADR_CTL0 = 3'd0;
  localparam logic [2:0] ADR_CTL1 = 3'd1;
  localparam logic [2:0] ADR_A0   = 3'd2;
  localparam logic [2:0] ADR_B0   = 3'd3;
  localparam logic [2:0] ADR_A1   = 3'd4;
  localparam logic [2:0] ADR_B1   = 3'd5;
  localparam logic [2:0] ADR_FCLR = 3'd6;

  localparam logic [3:0] SRC_EXT = 4'd8;

  typedef struct packed {
    logic [NUM_CH-1:0] tick;
    logic [NUM_CH-1:0] stop;
    logic [NUM_CH-1:0] invert;
    logic              cascade;
    logic [FLAG_W-1:0] flagClr;
  } tmr_strb_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [2:0]                    wrAddr,
  input  logic [CNT_W-1:0]              wrData,
  input  logic [NUM_CH-1:0]             extIn,
  output tmr_strb_t                     strb,
  output logic [NUM_CH-1:0][CNT_W-1:0]  aPend,
  output logic [NUM_CH-1:0][CNT_W-1:0]  bPend
);
  logic [NUM_CH-1:0][3:0] srcQ;
  logic [NUM_CH-1:0]      invQ;
  logic                   cascQ;
  logic [PRE_W-1:0]       preQ;
  logic [NUM_CH-1:0]      extRise;
  logic [NUM_CH-1:0]      tickV;
  logic [NUM_CH-1:0]      stopV;
  logic                   unusedData;

  assign unusedData = ^wrData[CNT_W-1:6];

  function automatic logic divTick(input logic [PRE_W-1:0] pre, input logic [3:0] src);
    case (src)
      4'd1:    return 1'b1;
      4'd2:    return pre[0];
      4'd3:    return &pre[2:0];
      4'd4:    return &pre[4:0];
      4'd5:    return &pre[5:0];
      4'd6:    return &pre[9:0];
      4'd7:    return &pre[12:0];
      default: return 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ  <= '0;
      invQ  <= '0;
      cascQ <= 1'b0;
      aPend <= '1;
      bPend <= '1;
      preQ  <= '0;
    end else begin
      preQ <= preQ + 1'b1;
      if (wrEn) begin
        case (wrAddr)
          ADR_CTL0: begin
            srcQ[0] <= wrData[3:0];
            invQ[0] <= wrData[4];
          end
          ADR_CTL1: begin
            srcQ[1] <= wrData[3:0];
            invQ[1] <= wrData[4];
            cascQ   <= wrData[5];
          end
          ADR_A0:  aPend[0] <= wrData;
          ADR_B0:  bPend[0] <= wrData;
          ADR_A1:  aPend[1] <= wrData;
          ADR_B1:  bPend[1] <= wrData;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [2:0] syncQ;
    always_ff @(posedge clk) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[1:0], extIn[g]};
    end
    assign extRise[g] = syncQ[1] & ~syncQ[2];
    assign tickV[g]   = (srcQ[g] == SRC_EXT) ? extRise[g] : divTick(preQ, srcQ[g]);
    assign stopV[g]   = (srcQ[g] == 4'd0) || (srcQ[g] > SRC_EXT);
  end

  always_comb begin
    strb.tick    = tickV;
    strb.stop    = stopV;
    strb.invert  = invQ;
    strb.cascade = cascQ;
    strb.flagClr = (wrEn && wrAddr == ADR_FCLR) ? wrData[FLAG_W-1:0] : '0;
  end
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tmr_strb_t                     strb,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  aPend,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  bPend,
  output logic [CNT_W-1:0]              cnt0,
  output logic [CNT_W-1:0]              cnt1,
  output logic [FLAG_W-1:0]             flags,
  output logic [NUM_CH-1:0]             pwmOut
);
  localparam int W2 = 2 * CNT_W;

  logic [NUM_CH-1:0][CNT_W-1:0] aAct, bAct;
  logic [W2-1:0] full, aFull, bFull;
  logic casc, max0, max1, clr0, clr1, wrap0, up1, ld0, ld1;
  logic [FLAG_W-1:0] setF;

  assign casc  = strb.cascade;
  assign full  = {cnt1, cnt0};
  assign aFull = {aAct[1], aAct[0]};
  assign bFull = {bAct[1], bAct[0]};
  assign max0  = (cnt0 == '1);
  assign max1  = (cnt1 == '1);

  always_comb begin
    clr0  = strb.tick[0] & (casc ? (full == aFull) : (cnt0 == aAct[0]));
    wrap0 = strb.tick[0] & max0 & ~clr0;
    clr1  = casc ? clr0 : (strb.tick[1] & (cnt1 == aAct[1]));
    up1   = casc ? wrap0 : strb.tick[1];
    ld0   = strb.stop[0] | clr0 | (casc ? (wrap0 & max1) : wrap0);
    ld1   = casc ? ld0 : (strb.stop[1] | clr1 | (strb.tick[1] & max1 & ~clr1));
    setF[0] = strb.tick[0] & max0;
    setF[1] = clr0;
    setF[2] = strb.tick[0] & (casc ? (full == bFull) : (cnt0 == bAct[0]));
    setF[3] = casc ? (strb.tick[0] & max0 & max1) : (strb.tick[1] & max1);
    setF[4] = ~casc & clr1;
    setF[5] = ~casc & strb.tick[1] & (cnt1 == bAct[1]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt0  <= '0;
      cnt1  <= '0;
      aAct  <= '1;
      bAct  <= '1;
      flags <= '0;
    end else begin
      if (clr0)              cnt0 <= '0;
      else if (strb.tick[0]) cnt0 <= cnt0 + 1'b1;
      if (clr1)              cnt1 <= '0;
      else if (up1)          cnt1 <= cnt1 + 1'b1;
      if (ld0) begin
        aAct[0] <= aPend[0];
        bAct[0] <= bPend[0];
      end
      if (ld1) begin
        aAct[1] <= aPend[1];
        bAct[1] <= bPend[1];
      end
      flags <= (flags & ~strb.flagClr) | setF;
    end
  end

  assign pwmOut[0] = (casc ? (full < bFull) : (cnt0 < bAct[0])) ^ strb.invert[0];
  assign pwmOut[1] = casc ? strb.invert[1] : ((cnt1 < bAct[1]) ^ strb.invert[1]);
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [1:0]        extIn,
  output logic [1:0]        pwmOut,
  output logic [CNT_W-1:0]  cnt0,
  output logic [CNT_W-1:0]  cnt1,
  output logic [5:0]        flags
);
  tmr_strb_t                     strb;
  logic [NUM_CH-1:0][CNT_W-1:0]  aPend, bPend;

  tmr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extIn(extIn), .strb(strb), .aPend(aPend), .bPend(bPend)
  );

  tmr_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .aPend(aPend), .bPend(bPend),
    .cnt0(cnt0), .cnt1(cnt1), .flags(flags), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input tmr_strb_t         strb,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CNT_W-1:0]  cnt1,
  input logic [5:0]        flags,
  input logic [1:0]        pwmOut
);
  logic [CNT_W-1:0] prev0;
  logic [CNT_W-1:0] prev0Inc;
  logic             unusedSig;

  assign unusedSig = ^{strb.stop, strb.invert[0], pwmOut[0]};

  always_ff @(posedge clk) prev0 <= cnt0;
  assign prev0Inc = prev0 + 1'b1;

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flags & $past(flags & ~strb.flagClr)) == $past(flags & ~strb.flagClr)));

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.tick[0]) |-> $stable(cnt0));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cnt0 == prev0 || cnt0 == prev0Inc || cnt0 == '0));

  // R8
  casc_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cascade && $past(strb.cascade) && cnt1 != $past(cnt1)) |-> (cnt0 == '0));

  // R8
  casc_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cascade && $past(strb.cascade) && $stable(strb.invert[1])) |-> $stable(pwmOut[1]));

  // R9
  casc_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cascade && $past(strb.cascade) && $past(flags[5:4] == 2'b00)) |-> (flags[5:4] == 2'b00));
endmodule

bind tmr_pair tmr_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .cnt0(cnt0), .cnt1(cnt1),
  .flags(flags), .pwmOut(pwmOut)
);

// File: tb/tmr_pair_tb.sv
module tmr_pair_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] extIn = '0;
  logic [1:0] pwmOut;
  logic [7:0] cnt0, cnt1;
  logic [5:0] flags;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  tmr_pair u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extIn(extIn), .pwmOut(pwmOut), .cnt0(cnt0), .cnt1(cnt1), .flags(flags)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic zeroAll();
    wr(3'd0, 8'd0); wr(3'd1, 8'd0);
    wr(3'd2, 8'd0); wr(3'd4, 8'd0);
    wr(3'd0, 8'd1); wr(3'd1, 8'd1);
    idle(300);
    wr(3'd0, 8'd0); wr(3'd1, 8'd0);
    wr(3'd6, 8'h3f);
  endtask

  task automatic countHigh0(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut[0]) h++;
    end
  endtask

  task automatic t_reset();
    chk(cnt0 == 0 && cnt1 == 0, "R10 counters", {cnt1, cnt0}, 0);
    chk(flags == 0, "R10 flags", flags, 0);
    chk(pwmOut == 2'b11, "R10 pins", pwmOut, 3);
    idle(20);
    chk(cnt0 == 0, "R10 stopped after reset", cnt0, 0);
  endtask

  task automatic t_div();
    int divs[7] = '{1, 2, 8, 32, 64, 1024, 8192};
    for (int k = 1; k <= 7; k++) begin
      logic [7:0] prev;
      int n;
      zeroAll();
      wr(3'd2, 8'hff);
      wr(3'd0, 8'(k));
      prev = cnt0; n = 0;
      while (cnt0 == prev && n < 20000) begin @(negedge clk); n++; end
      prev = cnt0; n = 0;
      while (cnt0 == prev && n < 20000) begin @(negedge clk); n++; end
      chk(n == divs[k-1], "R1 divider period", n, divs[k-1]);
    end
    wr(3'd0, 8'd0);
  endtask

  task automatic t_stop();
    logic [7:0] held;
    zeroAll();
    wr(3'd2, 8'hff);
    wr(3'd0, 8'd1);
    idle(20);
    wr(3'd0, 8'd0);
    held = cnt0;
    chk(held != 0, "R2 ran before stop", held, 1);
    idle(50);
    chk(cnt0 == held, "R2 code 0 holds", cnt0, held);
    wr(3'd0, 8'd12);
    idle(50);
    chk(cnt0 == held, "R2 code 12 holds", cnt0, held);
    wr(3'd0, 8'd0);
  endtask

  task automatic t_ext();
    logic [7:0] base;
    zeroAll();
    wr(3'd2, 8'hff);
    wr(3'd0, 8'd8);
    idle(5);
    base = cnt0;
    for (int p = 0; p < 6; p++) begin
      extIn[0] = 1'b1; idle(3);
      extIn[0] = 1'b0; idle(3);
    end
    idle(5);
    chk(8'(cnt0 - base) == 6, "R3 edge count", 8'(cnt0 - base), 6);
    base = cnt0;
    extIn[0] = 1'b1;
    idle(5);
    base = cnt0;
    idle(40);
    chk(cnt0 == base, "R3 level no count", cnt0, base);
    extIn[0] = 1'b0;
    wr(3'd0, 8'd0);
  endtask

  task automatic t_clear_pwm();
    int mx, zeros, h;
    zeroAll();
    wr(3'd2, 8'd9); wr(3'd3, 8'd3);
    wr(3'd0, 8'd1);
    mx = 0; zeros = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cnt0 > mx) mx = cnt0;
      if (cnt0 == 0) zeros++;
    end
    chk(mx == 9, "R4 max count", mx, 9);
    chk(zeros == 4, "R4 clears in 40", zeros, 4);
    countHigh0(20, h);
    chk(h == 6, "R5 duty 3/10", h, 6);
    wr(3'd0, 8'd0); wr(3'd3, 8'd0); wr(3'd0, 8'd1);
    countHigh0(20, h);
    chk(h == 0, "R5 B=0 low", h, 0);
    wr(3'd0, 8'd0); wr(3'd3, 8'd12); wr(3'd0, 8'd1);
    countHigh0(20, h);
    chk(h == 20, "R5 B>A high", h, 20);
    wr(3'd0, 8'd0); wr(3'd3, 8'd3); wr(3'd0, 8'h11);
    countHigh0(20, h);
    chk(h == 14, "R6 inverted duty", h, 14);
    wr(3'd0, 8'd0);
    wr(3'd4, 8'd4); wr(3'd5, 8'd2); wr(3'd1, 8'd1);
    h = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwmOut[1]) h++;
    end
    chk(h == 8, "R5 channel 1 duty 2/5", h, 8);
    wr(3'd1, 8'd0);
  endtask

  task automatic t_shadow();
    int mx, n;
    zeroAll();
    wr(3'd2, 8'd9);
    wr(3'd0, 8'd1);
    n = 0;
    while (cnt0 != 1 && n < 100) begin @(negedge clk); n++; end
    wr(3'd2, 8'd4);
    mx = cnt0; n = 0;
    while (cnt0 != 0 && n < 100) begin
      if (cnt0 > mx) mx = cnt0;
      @(negedge clk); n++;
    end
    chk(mx == 9, "R7 old period kept", mx, 9);
    mx = 0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (cnt0 > mx) mx = cnt0;
    end
    chk(mx == 4, "R7 new period after clear", mx, 4);
    wr(3'd0, 8'd0);
  endtask

  task automatic t_flags();
    zeroAll();
    wr(3'd2, 8'h10); wr(3'd3, 8'd5);
    wr(3'd0, 8'd1);
    idle(60);
    wr(3'd0, 8'd0);
    chk(flags == 6'b000110, "R9 match flags no overflow", flags, 6);
    wr(3'd6, 8'b0000_0010);
    chk(flags == 6'b000100, "R9 partial clear", flags, 4);
    idle(20);
    chk(flags == 6'b000100, "R9 sticky", flags, 4);
    zeroAll();
    wr(3'd2, 8'hff); wr(3'd3, 8'd5);
    wr(3'd0, 8'd1);
    idle(300);
    wr(3'd0, 8'd0);
    chk(flags == 6'b000111, "R9 overflow flag", flags, 7);
    wr(3'd6, 8'h3f);
  endtask

  task automatic t_cascade();
    int h, mx1, p1Hi;
    zeroAll();
    wr(3'd2, 8'hff); wr(3'd4, 8'h01);
    wr(3'd3, 8'h00); wr(3'd5, 8'h01);
    wr(3'd1, 8'h20);
    wr(3'd0, 8'd1);
    h = 0; mx1 = 0; p1Hi = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (pwmOut[0]) h++;
      if (pwmOut[1]) p1Hi++;
      if (cnt1 > mx1) mx1 = cnt1;
    end
    wr(3'd0, 8'd0);
    chk(h == 512, "R8 16-bit duty", h, 512);
    chk(mx1 == 1, "R8 upper count max", mx1, 1);
    chk(p1Hi == 0, "R8 pin1 idle", p1Hi, 0);
    chk(flags == 6'b000111, "R9 joined-mode flags", flags, 7);
    wr(3'd1, 8'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all requirements act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_div();
    t_stop();
    t_ext();
    t_clear_pwm();
    t_shadow();
    t_flags();
    t_cascade();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule